// File: doc/BRIEF.md
# Reference Clock Qualifier and Selector

This block watches up to twelve reference clocks with the system clock and decides which of them may drive a timing loop. Each reference gets two monitors. The first is an activity check: a reference fails if no rising edge has arrived for a programmable number of system cycles. The second is a frequency check: it counts rising edges during a shared gate window of fixed length and compares the count with a programmed expected value and tolerance. Four external loss-of-signal pins can each be enabled and steered to any one reference, and a steered pin that is high disqualifies that reference. A failed reference becomes usable again only after it has passed every check for a programmable number of consecutive clean gate windows.

The selector then names the active reference. The host can force one index. Without forcing, the selector takes the qualified reference with the best priority from a per-input priority table. It can work in revertive mode, where it always moves to the best candidate, or in non-revertive mode, where it stays on the current reference while that reference stays usable. When no reference is usable the selector raises a "none" flag, which a mode controller can use to enter holdover. A one-cycle pulse marks every change of the selection.

All pins are plain control and status levels. No data stream crosses the block, so it has no handshakes and no back-pressure.

Top module: `refmon_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every qualified flag is 0, `sel_none_o` is 1, `sel_idx_o` is 0 and `sel_chg_o` is 0.
- R2: A reference that has shown no rising edge for `act_limit` consecutive system cycles loses its qualified flag and does not regain it while the edges stay absent.
- R3: At the end of each gate window of `GATE_CYC` cycles, the rising-edge count of a reference is checked against `exp_cnt[i*CW +: CW]` ± `freq_tol`. A count outside that band clears the qualified flag.
- R4: Loss-of-signal pin j acts when `los_en[j]` is 1. It targets the reference whose index is in the field `los_map[j*IDXW +: IDXW]`. While the pin is high, that reference's qualified flag is 0 from the next cycle on.
- R5: A disqualified reference is qualified again only after `requal_win` consecutive gate windows in which it was active, free of loss-of-signal and in the frequency band for the whole window. A `requal_win` of 0 counts as 1.
- R6: With no forcing, the selector picks from the qualified references whose priority field `prio[i*PW +: PW]` is non-zero. The smallest priority value wins. On a tie, the lower index wins. A priority of 0 is never picked.
- R7: In revertive mode (`revertive` = 1), the selection moves to a better-priority reference as soon as that reference is qualified.
- R8: In non-revertive mode (`revertive` = 0), the current reference is kept while it stays qualified with a non-zero priority, even when a better one qualifies.
- R9: While `force_en` is 1, `sel_idx_o` equals `force_idx` one cycle later and `sel_none_o` is 0, whatever the qualification state.
- R10: With no forcing and no qualified reference of non-zero priority, `sel_none_o` is 1 and `sel_idx_o` keeps its last value.
- R11: `sel_chg_o` is high for exactly those cycles in which `sel_idx_o` or `sel_none_o` has just taken a new value. The selection registers follow the qualified flags one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | NREF | Reference clock inputs, sampled by the system clock |
| los_pin | input | NLOS | Loss-of-signal pins, active high |
| los_en | input | NLOS | Enable for each loss-of-signal pin |
| los_map | input | NLOS*IDXW | Target reference index for each pin |
| act_limit | input | IW | Cycles without an edge before a reference counts as inactive |
| exp_cnt | input | NREF*CW | Expected edge count per gate window, per reference |
| freq_tol | input | CW | Allowed deviation from the expected count |
| requal_win | input | GW | Clean windows needed to qualify again |
| prio | input | NREF*PW | Priority per reference, 0 = never picked automatically |
| force_en | input | 1 | Force the selection to force_idx |
| force_idx | input | IDXW | Forced reference index |
| revertive | input | 1 | 1 = revertive, 0 = non-revertive |
| qual_o | output | NREF | Qualified flag per reference |
| sel_idx_o | output | IDXW | Selected reference index |
| sel_none_o | output | 1 | No reference is selected |
| sel_chg_o | output | 1 | One-cycle pulse when the selection changes |

## Verification
The assertions assume that `force_idx` and every `los_map` field name an existing reference. They assume that `act_limit` is at least 1, that the loss-of-signal pins are already synchronous to the system clock, and that every reference stays high and low for at least two system cycles, so that the two-stage synchronizer sees each edge. The stimulus toggles references only at whole multiples of two or more system cycles, drives all controls on the falling clock edge, and uses only in-range indices for forcing and pin steering.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  // Selection policy derived from the force and revertive controls
  typedef enum logic [1:0] {
    PICK_AUTO_HOLD = 2'd0,
    PICK_AUTO_BEST = 2'd1,
    PICK_FORCED    = 2'd2
  } pick_mode_t;

  // True when cnt lies within exp +/- tol, evaluated without underflow
  function automatic logic in_band(input logic [16:0] cnt,
                                   input logic [16:0] exp,
                                   input logic [16:0] tol);
    logic [17:0] up;
    logic [17:0] dn;
    up = {1'b0, exp} + {1'b0, tol};
    dn = {1'b0, cnt} + {1'b0, tol};
    return (dn >= {1'b0, exp}) && ({1'b0, cnt} <= up);
  endfunction

endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] st1, st2, st3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1 <= '0;
      st2 <= '0;
      st3 <= '0;
    end else begin
      st1 <= async_i;
      st2 <= st1;
      st3 <= st2;
    end
  end

  assign rise_o = st2 & ~st3;
endmodule

// File: rtl/refmon_chan.sv
module refmon_chan #(
  parameter int CW = 8,
  parameter int IW = 8,
  parameter int GW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          los_i,
  input  logic          gate_end_i,
  input  logic [IW-1:0] act_limit_i,
  input  logic [CW-1:0] exp_i,
  input  logic [CW-1:0] tol_i,
  input  logic [GW-1:0] need_i,
  output logic          qual_o
);
  import refmon_pkg::*;

  localparam logic [IW-1:0] IDLE_MAX = {IW{1'b1}};
  localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};
  localparam logic [GW-1:0] GOOD_MAX = {GW{1'b1}};

  logic [IW-1:0] idle_q;
  logic [CW-1:0] ecnt_q;
  logic [GW-1:0] good_q;
  logic          clean_q;
  logic          qual_q;

  logic          inactive;
  logic          fault;
  logic [CW:0]   cnt_fin;
  logic          freq_ok;
  logic          pass;
  logic [GW:0]   good_inc;

  assign inactive = (idle_q >= act_limit_i);
  assign fault    = inactive | los_i;
  assign cnt_fin  = {1'b0, ecnt_q} + {{CW{1'b0}}, rise_i};
  assign freq_ok  = in_band(17'(cnt_fin), 17'(exp_i), 17'(tol_i));
  assign pass     = clean_q & ~fault & freq_ok;
  assign good_inc = {1'b0, good_q} + 1'b1;

  // Edge-free cycle counter for the activity check
  always_ff @(posedge clk) begin
    if (!rst_n)              idle_q <= '0;
    else if (rise_i)         idle_q <= '0;
    else if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
  end

  // Edge counter over the gate window
  always_ff @(posedge clk) begin
    if (!rst_n)                  ecnt_q <= '0;
    else if (gate_end_i)         ecnt_q <= '0;
    else if (rise_i && ecnt_q != CNT_MAX) ecnt_q <= ecnt_q + 1'b1;
  end

  // Window cleanliness and requalification hysteresis
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clean_q <= 1'b1;
      good_q  <= '0;
      qual_q  <= 1'b0;
    end else if (gate_end_i) begin
      clean_q <= 1'b1;
      if (pass) begin
        good_q <= (good_q == GOOD_MAX) ? good_q : good_inc[GW-1:0];
        if (good_inc >= {1'b0, need_i}) qual_q <= 1'b1;
      end else begin
        good_q <= '0;
        qual_q <= 1'b0;
      end
    end else if (fault) begin
      clean_q <= 1'b0;
      qual_q  <= 1'b0;
    end
  end

  assign qual_o = qual_q;
endmodule

// File: rtl/refmon_sel.sv
module refmon_sel #(
  parameter int NREF = 12,
  parameter int PW   = 4,
  parameter int IDXW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREF-1:0]    qual_i,
  input  logic [NREF*PW-1:0] prio_i,
  input  logic               force_en_i,
  input  logic [IDXW-1:0]    force_idx_i,
  input  logic               revertive_i,
  output logic [IDXW-1:0]    sel_idx_o,
  output logic               sel_none_o,
  output logic               sel_chg_o
);
  import refmon_pkg::*;

  logic [IDXW-1:0] sel_q;
  logic            none_q;
  logic            chg_q;

  logic            best_found;
  logic [IDXW-1:0] best_idx;
  logic [PW-1:0]   best_p;
  logic [PW-1:0]   cur_p;
  logic            keep_cur;
  pick_mode_t      mode;
  logic [IDXW-1:0] nxt_idx;
  logic            nxt_none;

  // Best candidate: smallest non-zero priority, lower index on ties
  always_comb begin
    best_found = 1'b0;
    best_idx   = '0;
    best_p     = '1;
    for (int i = 0; i < NREF; i++) begin
      if (qual_i[i] && prio_i[i*PW +: PW] != '0 &&
          (!best_found || prio_i[i*PW +: PW] < best_p)) begin
        best_found = 1'b1;
        best_idx   = IDXW'(i);
        best_p     = prio_i[i*PW +: PW];
      end
    end
  end

  always_comb begin
    cur_p = '0;
    for (int i = 0; i < NREF; i++)
      if (sel_q == IDXW'(i)) cur_p = prio_i[i*PW +: PW];
  end

  assign keep_cur = ~none_q & qual_i[sel_q] & (cur_p != '0);
  assign mode = force_en_i  ? PICK_FORCED :
                revertive_i ? PICK_AUTO_BEST : PICK_AUTO_HOLD;

  always_comb begin
    nxt_idx  = sel_q;
    nxt_none = 1'b0;
    case (mode)
      PICK_FORCED: nxt_idx = force_idx_i;
      PICK_AUTO_HOLD: begin
        if (keep_cur)        nxt_idx  = sel_q;
        else if (best_found) nxt_idx  = best_idx;
        else                 nxt_none = 1'b1;
      end
      default: begin
        if (best_found) nxt_idx  = best_idx;
        else            nxt_none = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      none_q <= 1'b1;
      chg_q  <= 1'b0;
    end else begin
      sel_q  <= nxt_idx;
      none_q <= nxt_none;
      chg_q  <= (nxt_idx != sel_q) | (nxt_none != none_q);
    end
  end

  assign sel_idx_o  = sel_q;
  assign sel_none_o = none_q;
  assign sel_chg_o  = chg_q;
endmodule

// File: rtl/refmon_top.sv
module refmon_top #(
  parameter int NREF     = 12,
  parameter int NLOS     = 4,
  parameter int CW       = 8,
  parameter int IW       = 8,
  parameter int GW       = 3,
  parameter int PW       = 4,
  parameter int GATE_CYC = 64,
  localparam int IDXW    = $clog2(NREF),
  localparam int GCW     = $clog2(GATE_CYC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREF-1:0]      ref_in,
  input  logic [NLOS-1:0]      los_pin,
  input  logic [NLOS-1:0]      los_en,
  input  logic [NLOS*IDXW-1:0] los_map,
  input  logic [IW-1:0]        act_limit,
  input  logic [NREF*CW-1:0]   exp_cnt,
  input  logic [CW-1:0]        freq_tol,
  input  logic [GW-1:0]        requal_win,
  input  logic [NREF*PW-1:0]   prio,
  input  logic                 force_en,
  input  logic [IDXW-1:0]      force_idx,
  input  logic                 revertive,
  output logic [NREF-1:0]      qual_o,
  output logic [IDXW-1:0]      sel_idx_o,
  output logic                 sel_none_o,
  output logic                 sel_chg_o
);
  localparam logic [GCW-1:0] GATE_LAST = GCW'(GATE_CYC - 1);

  logic [GCW-1:0]  gcnt_q;
  logic            gate_end;
  logic [NREF-1:0] rise;
  logic [NREF-1:0] los_hit;
  logic [GW-1:0]   need;

  // Shared gate window for all frequency monitors
  always_ff @(posedge clk) begin
    if (!rst_n)        gcnt_q <= '0;
    else if (gate_end) gcnt_q <= '0;
    else               gcnt_q <= gcnt_q + 1'b1;
  end
  assign gate_end = (gcnt_q == GATE_LAST);

  assign need = (requal_win == '0) ? GW'(1) : requal_win;

  refmon_sync #(.N(NREF)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ref_in),
    .rise_o  (rise)
  );

  // Steer each enabled loss-of-signal pin onto its target reference
  for (genvar i = 0; i < NREF; i++) begin : g_los
    logic [NLOS-1:0] hit_v;
    for (genvar j = 0; j < NLOS; j++) begin : g_pin
      assign hit_v[j] = los_en[j] & los_pin[j] &
                        (los_map[j*IDXW +: IDXW] == IDXW'(i));
    end
    assign los_hit[i] = |hit_v;
  end

  for (genvar i = 0; i < NREF; i++) begin : g_chan
    refmon_chan #(.CW(CW), .IW(IW), .GW(GW)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .rise_i      (rise[i]),
      .los_i       (los_hit[i]),
      .gate_end_i  (gate_end),
      .act_limit_i (act_limit),
      .exp_i       (exp_cnt[i*CW +: CW]),
      .tol_i       (freq_tol),
      .need_i      (need),
      .qual_o      (qual_o[i])
    );
  end

  refmon_sel #(.NREF(NREF), .PW(PW), .IDXW(IDXW)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .qual_i      (qual_o),
    .prio_i      (prio),
    .force_en_i  (force_en),
    .force_idx_i (force_idx),
    .revertive_i (revertive),
    .sel_idx_o   (sel_idx_o),
    .sel_none_o  (sel_none_o),
    .sel_chg_o   (sel_chg_o)
  );
endmodule

// File: rtl/refmon_chk.sv
module refmon_chk #(
  parameter int NREF = 12,
  parameter int NLOS = 4,
  parameter int IDXW = 4,
  parameter int PW   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NLOS-1:0]      los_pin,
  input logic [NLOS-1:0]      los_en,
  input logic [NLOS*IDXW-1:0] los_map,
  input logic [NREF*PW-1:0]   prio,
  input logic                 force_en,
  input logic [IDXW-1:0]      force_idx,
  input logic [NREF-1:0]      qual_o,
  input logic [IDXW-1:0]      sel_idx_o,
  input logic                 sel_none_o,
  input logic                 sel_chg_o
);
  logic [NREF-1:0]    los_mask;
  logic               p_rst;
  logic               p_force;
  logic [IDXW-1:0]    p_fidx;
  logic [NREF-1:0]    p_qual;
  logic [NREF-1:0]    p_los;
  logic [NREF*PW-1:0] p_prio;
  logic [IDXW-1:0]    p_sel;
  logic               p_none;
  logic               sel_ok;

  always_comb begin
    los_mask = '0;
    for (int i = 0; i < NREF; i++)
      for (int j = 0; j < NLOS; j++)
        if (los_en[j] && los_pin[j] && los_map[j*IDXW +: IDXW] == IDXW'(i))
          los_mask[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    p_rst   <= rst_n;
    p_force <= force_en;
    p_fidx  <= force_idx;
    p_qual  <= qual_o;
    p_los   <= los_mask;
    p_prio  <= prio;
    p_sel   <= sel_idx_o;
    p_none  <= sel_none_o;
  end

  always_comb begin
    sel_ok = 1'b0;
    for (int i = 0; i < NREF; i++)
      if (sel_idx_o == IDXW'(i))
        sel_ok = p_qual[i] && (p_prio[i*PW +: PW] != '0);
  end

  // R4: a steered, asserted pin leaves its reference unqualified next cycle
  assert_los_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    p_rst |-> ((qual_o & p_los) == '0));

  // R9: forcing sets the index and clears the none flag
  assert_forced_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rst && p_force) |-> (sel_idx_o == p_fidx && !sel_none_o));

  // R6: an automatic pick was qualified with non-zero priority a cycle before
  assert_auto_pick_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rst && !p_force && !sel_none_o) |-> sel_ok);

  // R11: the change pulse appears only with a change
  assert_chg_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rst && sel_chg_o) |-> (sel_idx_o != p_sel || sel_none_o != p_none));

  // R11: every change is marked by the pulse
  assert_chg_marked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rst && (sel_idx_o != p_sel || sel_none_o != p_none)) |-> sel_chg_o);

  // R1: first cycle out of reset shows the idle selection
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_rst) |-> (qual_o == '0 && sel_none_o && !sel_chg_o));
endmodule

bind refmon_top refmon_chk #(.NREF(NREF), .NLOS(NLOS), .IDXW(IDXW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .los_pin   (los_pin),
  .los_en    (los_en),
  .los_map   (los_map),
  .prio      (prio),
  .force_en  (force_en),
  .force_idx (force_idx),
  .qual_o    (qual_o),
  .sel_idx_o (sel_idx_o),
  .sel_none_o(sel_none_o),
  .sel_chg_o (sel_chg_o)
);

// File: tb/tb_refmon_top.sv
module tb_refmon_top;
  localparam int NREF = 12, NLOS = 4, CW = 8, IW = 8, GW = 3, PW = 4, GATE = 64;
  localparam int IDXW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREF-1:0]      ref_in = '0;
  logic [NLOS-1:0]      los_pin = '0;
  logic [NLOS-1:0]      los_en = '0;
  logic [NLOS*IDXW-1:0] los_map = '0;
  logic [IW-1:0]        act_limit = 8'd20;
  logic [NREF*CW-1:0]   exp_cnt = '0;
  logic [CW-1:0]        freq_tol = 8'd1;
  logic [GW-1:0]        requal_win = 3'd2;
  logic [NREF*PW-1:0]   prio = '0;
  logic                 force_en = 1'b0;
  logic [IDXW-1:0]      force_idx = '0;
  logic                 revertive = 1'b1;
  logic [NREF-1:0]      qual_o;
  logic [IDXW-1:0]      sel_idx_o;
  logic                 sel_none_o;
  logic                 sel_chg_o;

  refmon_top dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .los_pin(los_pin), .los_en(los_en),
    .los_map(los_map), .act_limit(act_limit), .exp_cnt(exp_cnt), .freq_tol(freq_tol),
    .requal_win(requal_win), .prio(prio), .force_en(force_en), .force_idx(force_idx),
    .revertive(revertive), .qual_o(qual_o), .sel_idx_o(sel_idx_o),
    .sel_none_o(sel_none_o), .sel_chg_o(sel_chg_o)
  );

  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference generators: half period in system cycles, 0 = stopped
  int hp [NREF];
  int hc [NREF];
  initial begin
    for (int i = 0; i < NREF; i++) begin hp[i] = 2; hc[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < NREF; i++) begin
        if (hp[i] != 0) begin
          hc[i]++;
          if (hc[i] >= hp[i]) begin hc[i] = 0; ref_in[i] = ~ref_in[i]; end
        end
      end
    end
  end

  // Behavioural reference model
  int m_s1 [NREF], m_s2 [NREF], m_s3 [NREF];
  int m_idle [NREF], m_ec [NREF], m_good [NREF], m_clean [NREF];
  logic [NREF-1:0] m_qual;
  int m_sel, m_none, m_chg, m_g;

  function automatic int pr(input int i);
    return int'(prio[i*PW +: PW]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREF; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0;
        m_idle[i] = 0; m_ec[i] = 0; m_good[i] = 0; m_clean[i] = 1;
      end
      m_qual = '0; m_sel = 0; m_none = 1; m_chg = 0; m_g = 0;
    end else begin
      int best, bp, ni, nn, need;
      bit gend;
      gend = (m_g == GATE - 1);
      need = (requal_win == 0) ? 1 : int'(requal_win);
      best = -1; bp = 99;
      for (int i = 0; i < NREF; i++)
        if (m_qual[i] && pr(i) != 0 && pr(i) < bp) begin best = i; bp = pr(i); end
      if (force_en) begin ni = int'(force_idx); nn = 0; end
      else if (!revertive && m_none == 0 && m_qual[m_sel] && pr(m_sel) != 0) begin
        ni = m_sel; nn = 0;
      end else if (best >= 0) begin ni = best; nn = 0; end
      else begin ni = m_sel; nn = 1; end
      m_chg = (ni != m_sel || nn != m_none) ? 1 : 0;
      m_sel = ni; m_none = nn;
      for (int i = 0; i < NREF; i++) begin
        int e, fin, ex, tl;
        bit lh, flt, ok;
        e  = (m_s2[i] == 1 && m_s3[i] == 0) ? 1 : 0;
        lh = 1'b0;
        for (int j = 0; j < NLOS; j++)
          if (los_en[j] && los_pin[j] && int'(los_map[j*IDXW +: IDXW]) == i) lh = 1'b1;
        flt = (m_idle[i] >= int'(act_limit)) || lh;
        fin = m_ec[i] + e;
        ex  = int'(exp_cnt[i*CW +: CW]);
        tl  = int'(freq_tol);
        ok  = (fin >= ex - tl) && (fin <= ex + tl);
        if (gend) begin
          if (m_clean[i] == 1 && !flt && ok) begin
            if (m_good[i] + 1 >= need) m_qual[i] = 1'b1;
            if (m_good[i] < 7) m_good[i]++;
          end else begin
            m_good[i] = 0; m_qual[i] = 1'b0;
          end
          m_ec[i] = 0; m_clean[i] = 1;
        end else begin
          if (flt) begin m_qual[i] = 1'b0; m_clean[i] = 0; end
          if (e == 1 && m_ec[i] < 255) m_ec[i]++;
        end
        if (e == 1) m_idle[i] = 0;
        else if (m_idle[i] < 255) m_idle[i]++;
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = int'(ref_in[i]);
      end
      m_g = gend ? 0 : m_g + 1;
    end
  end

  // Cycle-by-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        chk("R2 R3 R4 R5 qual vs model", int'(qual_o), int'(m_qual));
        chk("R6 R7 R8 R9 sel vs model", int'(sel_idx_o), m_sel);
        chk("R10 none vs model", int'(sel_none_o), m_none);
        chk("R11 chg vs model", int'(sel_chg_o), m_chg);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_prio(input int i, input int v);
    prio[i*PW +: PW] = PW'(v);
  endtask

  initial begin
    for (int i = 0; i < NREF; i++) begin
      exp_cnt[i*CW +: CW] = 8'd16;
      set_prio(i, 5);
    end
    set_prio(0, 0); set_prio(1, 3); set_prio(2, 2); set_prio(3, 2);
    hp[5] = 3;
    hp[7] = 0;
    los_map[1*IDXW +: IDXW] = 4'd2;
    wait_cyc(3);
    chk("R1 reset qual", int'(qual_o), 0);
    chk("R1 reset none", int'(sel_none_o), 1);
    chk("R1 reset sel", int'(sel_idx_o), 0);
    chk("R1 reset chg", int'(sel_chg_o), 0);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 first cycle none", int'(sel_none_o), 1);
    wait_cyc(400);
    chk("R2 R3 R5 qualified mask", int'(qual_o), 12'hF5F);
    chk("R6 tie goes to lower index, prio 0 skipped", int'(sel_idx_o), 2);
    chk("R10 none cleared", int'(sel_none_o), 0);

    los_en[1] = 1'b1; los_pin[1] = 1'b1;
    wait_cyc(3);
    chk("R4 steered pin drops ref 2", int'(qual_o[2]), 0);
    chk("R7 moved to ref 3", int'(sel_idx_o), 3);
    los_pin[1] = 1'b0;
    wait_cyc(100);
    chk("R5 not back after one window", int'(qual_o[2]), 0);
    wait_cyc(230);
    chk("R5 requalified ref 2", int'(qual_o[2]), 1);
    chk("R7 revertive returns to ref 2", int'(sel_idx_o), 2);

    revertive = 1'b0;
    los_pin[1] = 1'b1;
    wait_cyc(3);
    chk("R8 off ref 2 to ref 3", int'(sel_idx_o), 3);
    los_pin[1] = 1'b0;
    wait_cyc(330);
    chk("R8 ref 2 qualified again", int'(qual_o[2]), 1);
    chk("R8 non-revertive keeps ref 3", int'(sel_idx_o), 3);

    hp[3] = 0;
    wait_cyc(40);
    chk("R2 stopped ref 3 dropped", int'(qual_o), 12'hF57);
    chk("R8 leaves lost ref for best", int'(sel_idx_o), 2);

    force_idx = 4'd7; force_en = 1'b1;
    wait_cyc(2);
    chk("R9 forced to unqualified ref 7", int'(sel_idx_o), 7);
    chk("R9 forced clears none", int'(sel_none_o), 0);
    force_en = 1'b0;
    wait_cyc(2);
    chk("R8 release of force picks best", int'(sel_idx_o), 2);

    freq_tol = 8'd6;
    wait_cyc(330);
    chk("R3 wider band qualifies ref 5", int'(qual_o), 12'hF77);

    for (int i = 0; i < NREF; i++) set_prio(i, 0);
    wait_cyc(2);
    chk("R10 no usable priority gives none", int'(sel_none_o), 1);
    chk("R10 index held", int'(sel_idx_o), 2);
    set_prio(9, 1);
    wait_cyc(2);
    chk("R6 only non-zero priority picked", int'(sel_idx_o), 9);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule